// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Interface

This block is the device-side bit layer of an open-drain single-wire serial bus. It watches the bus line through a synchronizer and drives an active-high pull-down enable that the pad turns into an open-drain low. All of its timing is counted from a 1 µs clock-enable tick.

The block measures each low period the master makes. A low that lasts long enough, and not too long, is a bus reset. After a reset the block waits for the line to rise and then answers with a presence pulse of its own. Any other falling edge starts a time slot. A mode input from the upper layer selects the slot type:
- In a write slot the block samples the line at a fixed point after the edge.
- In a read slot the block sends a bit it latched at the edge. For a 0 it holds the line low for a fixed time. For a 1 it leaves the line alone.

The upper layer receives three things: a reset strobe, a received-bit strobe with its value, and a strobe that acknowledges each bit taken for sending.

Top module: `ow_slave_phy`

## Requirements
- R1: After reset, `bus_pd_o`, `rst_det_o`, `rx_valid_o` and `tx_ack_o` are all 0.
- R2: When the line rises after a low of at least 480 µs and less than 960 µs, `rst_det_o` pulses for one cycle. A low of 440 µs gives no strobe.
- R3: After a detected reset, the block waits 30 µs from the rise and then holds `bus_pd_o` at 1 for 120 µs. Synchronizer latency adds at most a few µs.
- R4: A low of 960 µs or more gives no reset strobe and no presence pulse.
- R5: In a write slot (`rd_mode_i`=0 at the falling edge), `rx_valid_o` pulses exactly once. `rx_bit_o` then carries the line level 30 µs after the edge: 1 for a short master low, 0 for a 60 µs low.
- R6: In a read slot with a latched bit of 0, `bus_pd_o` is 1 from the edge for 30 µs. `tx_ack_o` pulses once at the edge. `tx_bit_i` is latched there, so a later change has no effect on that slot.
- R7: In a read slot with a latched bit of 1, `bus_pd_o` stays 0 for the whole slot.
- R8: The block never drives the line unless a master falling edge or a detected reset came first. An idle bus sees `bus_pd_o`=0.
- R9: A slot whose low is stretched into a reset finishes its own action once, with no second action. It is then followed by a reset strobe and a normal presence pulse.
- R10: A read slot produces no `rx_valid_o`, and a write slot produces no `tx_ack_o`.
- R11: All timers advance only on `tick_i`. While `tick_i` is held at 0, a read-0 drive stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 µs clock-enable |
| bus_i | input | 1 | Raw bus line level |
| rd_mode_i | input | 1 | 1: next slot is a read slot (device sends) |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| bus_pd_o | output | 1 | Open-drain pull-down enable, active high |
| rst_det_o | output | 1 | One-cycle strobe on a valid bus reset |
| rx_valid_o | output | 1 | One-cycle strobe for a received bit |
| rx_bit_o | output | 1 | Received bit value |
| tx_ack_o | output | 1 | One-cycle strobe when a send bit is latched |

## Verification
Slot handling and reset detection can meet in the same bus event. A read slot's falling edge starts a 30 µs drive, and the master can hold that same low until it turns into a reset. The bench provokes this by opening a read-0 slot and keeping the master low for 600 µs. The case is judged by three observations: exactly one send acknowledge and no received bit, one reset strobe at the rise, and a presence pulse whose delay and width match the plain reset case.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSMP,
    ST_RHOLD,
    ST_WHIGH,
    ST_PWAIT,
    ST_PLOW
  } slot_st_e;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], bus_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_o = sh_q[STAGES-1];
  assign fall_o = prev_q & ~line_o;
  assign rise_o = ~prev_q & line_o;
endmodule

// File: rtl/ow_low_meter.sv
module ow_low_meter #(
  parameter int RST_MIN_US = 480,
  parameter int RST_MAX_US = 960,
  parameter int CW         = $clog2(RST_MAX_US + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic rise_i,
  input  logic mask_i,
  output logic rst_evt_o
);
  logic [CW-1:0] cnt_q;

  // saturating low-width counter; clears while the line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (line_i)                             cnt_q <= '0;
    else if (tick_i && cnt_q < CW'(RST_MAX_US))  cnt_q <= cnt_q + CW'(1);
  end

  assign rst_evt_o = rise_i & ~mask_i &
                     (cnt_q >= CW'(RST_MIN_US)) & (cnt_q < CW'(RST_MAX_US));

  p_cnt_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(RST_MAX_US));

  p_evt_after_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt_o |-> !$past(line_i));
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_pkg::*;
#(
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int SAMPLE_US  = 30,
  parameter int HOLD0_US   = 30,
  parameter int TW         = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic fall_i,
  input  logic rst_evt_i,
  input  logic rd_mode_i,
  input  logic tx_bit_i,
  output logic pres_busy_o,
  output logic rst_det_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic tx_ack_o,
  output logic pd_o
);
  slot_st_e      st_q, nxt_st;
  logic [TW-1:0] cnt_q, lim_m1;
  logic          tx_q;

  always_comb begin
    lim_m1 = TW'(0);
    nxt_st = ST_WHIGH;
    unique case (st_q)
      ST_PWAIT: begin lim_m1 = TW'(PD_WAIT_US - 1); nxt_st = ST_PLOW; end
      ST_PLOW:  lim_m1 = TW'(PD_LOW_US - 1);
      ST_WSMP:  lim_m1 = TW'(SAMPLE_US - 1);
      ST_RHOLD: lim_m1 = TW'(HOLD0_US - 1);
      default:  lim_m1 = TW'(0);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      tx_q       <= 1'b1;
      rst_det_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
      tx_ack_o   <= 1'b0;
    end else begin
      rst_det_o  <= rst_evt_i;
      rx_valid_o <= 1'b0;
      tx_ack_o   <= 1'b0;
      if (rst_evt_i) begin
        st_q  <= ST_PWAIT;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (fall_i) begin
            cnt_q <= '0;
            if (rd_mode_i) begin
              st_q     <= ST_RHOLD;
              tx_q     <= tx_bit_i;
              tx_ack_o <= 1'b1;
            end else begin
              st_q <= ST_WSMP;
            end
          end
          ST_WSMP, ST_RHOLD, ST_PWAIT, ST_PLOW: if (tick_i) begin
            if (cnt_q == lim_m1) begin
              cnt_q <= '0;
              st_q  <= nxt_st;
              if (st_q == ST_WSMP) begin
                rx_valid_o <= 1'b1;
                rx_bit_o   <= line_i;
              end
            end else begin
              cnt_q <= cnt_q + TW'(1);
            end
          end
          ST_WHIGH: if (line_i) st_q <= ST_IDLE;
          default:  st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign pd_o        = (st_q == ST_PLOW) | ((st_q == ST_RHOLD) & ~tx_q);
  assign pres_busy_o = (st_q == ST_PWAIT) | (st_q == ST_PLOW);

  p_rst_to_pwait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt_i |=> (st_q == ST_PWAIT));

  p_ack_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_o |-> (tx_q == $past(tx_bit_i)));

  p_slot_from_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WSMP || st_q == ST_RHOLD) && $past(st_q) == ST_IDLE) |-> $past(fall_i));

  p_rx_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_hold_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RHOLD && !tick_i && !rst_evt_i) |=> (st_q == ST_RHOLD));
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_MIN_US  = 480,
  parameter int RST_MAX_US  = 960,
  parameter int PD_WAIT_US  = 30,
  parameter int PD_LOW_US   = 120,
  parameter int SAMPLE_US   = 30,
  parameter int HOLD0_US    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bus_i,
  input  logic rd_mode_i,
  input  logic tx_bit_i,
  output logic bus_pd_o,
  output logic rst_det_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic tx_ack_o
);
  localparam int CW  = $clog2(RST_MAX_US + 1);
  localparam int TM1 = (PD_WAIT_US > PD_LOW_US) ? PD_WAIT_US : PD_LOW_US;
  localparam int TM2 = (SAMPLE_US > HOLD0_US) ? SAMPLE_US : HOLD0_US;
  localparam int TW  = $clog2(((TM1 > TM2) ? TM1 : TM2) + 1);

  logic line, fall, rise, rst_evt, pres_busy;

  ow_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  (bus_i),
    .line_o (line),
    .fall_o (fall),
    .rise_o (rise)
  );

  ow_low_meter #(.RST_MIN_US(RST_MIN_US), .RST_MAX_US(RST_MAX_US), .CW(CW)) i_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line),
    .rise_i    (rise),
    .mask_i    (pres_busy),
    .rst_evt_o (rst_evt)
  );

  ow_slot_ctrl #(
    .PD_WAIT_US (PD_WAIT_US),
    .PD_LOW_US  (PD_LOW_US),
    .SAMPLE_US  (SAMPLE_US),
    .HOLD0_US   (HOLD0_US),
    .TW         (TW)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .line_i      (line),
    .fall_i      (fall),
    .rst_evt_i   (rst_evt),
    .rd_mode_i   (rd_mode_i),
    .tx_bit_i    (tx_bit_i),
    .pres_busy_o (pres_busy),
    .rst_det_o   (rst_det_o),
    .rx_valid_o  (rx_valid_o),
    .rx_bit_o    (rx_bit_o),
    .tx_ack_o    (tx_ack_o),
    .pd_o        (bus_pd_o)
  );
endmodule

// File: tb/test_ow_slave_phy.sv
module test_ow_slave_phy;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic m_low = 1'b0;
  logic rd_mode = 1'b0;
  logic tx_bit = 1'b1;
  logic bus_pd, rst_det, rx_valid, rx_bit, tx_ack;
  logic wire_lvl;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int rst_cnt = 0, rx_cnt = 0, ack_cnt = 0, pd_cyc = 0;
  logic last_rx = 1'b0;
  int b_rst, b_rx, b_ack, b_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wire_lvl = ~(m_low | bus_pd);

  ow_slave_phy i_ow_slave_phy (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick_en),
    .bus_i      (wire_lvl),
    .rd_mode_i  (rd_mode),
    .tx_bit_i   (tx_bit),
    .bus_pd_o   (bus_pd),
    .rst_det_o  (rst_det),
    .rx_valid_o (rx_valid),
    .rx_bit_o   (rx_bit),
    .tx_ack_o   (tx_ack)
  );

  always @(negedge clk) if (rst_n) begin
    if (rst_det) rst_cnt++;
    if (rx_valid) begin rx_cnt++; last_rx = rx_bit; end
    if (tx_ack) ack_cnt++;
    if (bus_pd) pd_cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic snap();
    b_rst = rst_cnt; b_rx = rx_cnt; b_ack = ack_cnt; b_pd = pd_cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_low(input int n);
    @(negedge clk) m_low = 1'b1;
    repeat (n) @(negedge clk);
    m_low = 1'b0;
  endtask

  task automatic meas_presence(output int w, output int h);
    w = 0; h = 0;
    while (!bus_pd && w < 400) begin @(negedge clk); w++; end
    while (bus_pd && h < 400) begin @(negedge clk); h++; end
  endtask

  task automatic t_reset_state();
    chk(bus_pd == 0,   "R1 pd", bus_pd, 0);
    chk(rst_det == 0,  "R1 rst_det", rst_det, 0);
    chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    chk(tx_ack == 0,   "R1 tx_ack", tx_ack, 0);
  endtask

  task automatic t_idle_quiet();
    snap(); idle(500);
    chk(pd_cyc == b_pd, "R8 idle pd", pd_cyc - b_pd, 0);
    chk(ack_cnt == b_ack && rx_cnt == b_rx, "R8 idle strobes", ack_cnt - b_ack + rx_cnt - b_rx, 0);
  endtask

  task automatic t_reset_presence();
    int w, h;
    rd_mode = 1'b0; snap();
    master_low(600);
    meas_presence(w, h);
    chk(rst_cnt - b_rst == 1, "R2 reset strobe", rst_cnt - b_rst, 1);
    chk(w >= 28 && w <= 40,   "R3 presence wait", w, 33);
    chk(h == 120,             "R3 presence width", h, 120);
    idle(50);
  endtask

  task automatic t_short_low();
    rd_mode = 1'b0; snap();
    master_low(440); idle(300);
    chk(rst_cnt == b_rst, "R2 440us no reset", rst_cnt - b_rst, 0);
    chk(pd_cyc == b_pd,   "R2 440us no presence", pd_cyc - b_pd, 0);
  endtask

  task automatic t_min_reset();
    int w, h;
    rd_mode = 1'b0; snap();
    master_low(520);
    meas_presence(w, h);
    chk(rst_cnt - b_rst == 1, "R2 520us reset", rst_cnt - b_rst, 1);
    idle(50);
  endtask

  task automatic t_long_low();
    rd_mode = 1'b0; snap();
    master_low(1000); idle(300);
    chk(rst_cnt == b_rst, "R4 long low no reset", rst_cnt - b_rst, 0);
    chk(pd_cyc == b_pd,   "R4 long low no presence", pd_cyc - b_pd, 0);
  endtask

  task automatic t_write();
    rd_mode = 1'b0; snap();
    master_low(5); idle(80);
    chk(rx_cnt - b_rx == 1, "R5 write1 strobe count", rx_cnt - b_rx, 1);
    chk(last_rx == 1'b1,    "R5 write1 value", last_rx, 1);
    chk(ack_cnt == b_ack,   "R10 no ack in write", ack_cnt - b_ack, 0);
    snap();
    master_low(60); idle(40);
    chk(rx_cnt - b_rx == 1, "R5 write0 strobe count", rx_cnt - b_rx, 1);
    chk(last_rx == 1'b0,    "R5 write0 value", last_rx, 0);
  endtask

  task automatic t_read0();
    int n;
    rd_mode = 1'b1; tx_bit = 1'b0; snap();
    master_low(5);
    tx_bit = 1'b1; // changed after the edge: must not affect this slot
    n = 5;
    while (!wire_lvl && n < 400) begin @(negedge clk); n++; end
    idle(40);
    chk(n >= 28 && n <= 40,    "R6 read0 low time", n, 33);
    chk(ack_cnt - b_ack == 1,  "R6 ack count", ack_cnt - b_ack, 1);
    chk(rx_cnt == b_rx,        "R10 no rx in read", rx_cnt - b_rx, 0);
  endtask

  task automatic t_read1();
    rd_mode = 1'b1; tx_bit = 1'b1; snap();
    master_low(5); idle(60);
    chk(pd_cyc == b_pd,       "R7 read1 no drive", pd_cyc - b_pd, 0);
    chk(ack_cnt - b_ack == 1, "R7 read1 ack", ack_cnt - b_ack, 1);
  endtask

  task automatic t_tick_freeze();
    rd_mode = 1'b1; tx_bit = 1'b0;
    master_low(5); idle(5);
    tick_en = 1'b0; idle(100);
    chk(bus_pd == 1'b1, "R11 frozen drive", bus_pd, 1);
    tick_en = 1'b1; idle(60);
    chk(bus_pd == 1'b0, "R11 drive released", bus_pd, 0);
  endtask

  task automatic t_cancel();
    int w, h;
    rd_mode = 1'b1; tx_bit = 1'b0; snap();
    master_low(600);
    meas_presence(w, h);
    chk(ack_cnt - b_ack == 1, "R9 single slot action", ack_cnt - b_ack, 1);
    chk(rx_cnt == b_rx,       "R9 no rx", rx_cnt - b_rx, 0);
    chk(rst_cnt - b_rst == 1, "R9 reset strobe", rst_cnt - b_rst, 1);
    chk(w >= 28 && w <= 40 && h == 120, "R9 presence", h, 120);
    idle(50);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset_state();
    t_idle_quiet();
    t_reset_presence();
    t_short_low();
    t_min_reset();
    t_long_low();
    t_write();
    t_read0();
    t_read1();
    t_tick_freeze();
    t_cancel();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule